// File: doc/BRIEF.md
# Sequencer Instruction Dispatch Controller

This block reads a program of 64-bit instruction words from a synchronous instruction memory, one word at a time, and carries out all control flow locally. Control flow covers counted loops, jumps, subroutine calls with a return stack, comparisons against an 8-bit condition register, and loading that register from an incoming message stream. Instructions meant for the playback engines (waveform, marker, wait and sync) are passed out whole on a valid/ready port, together with their two-bit engine-select field.

Each instruction takes a fetch cycle, a latch cycle and an execute cycle. Engine-bound words then wait on the output handshake. A register-load instruction waits for a message. A sync instruction also waits for the engines to report idle. A call that finds the stack full, or a return that finds it empty, raises a sticky error and stops dispatch until reset.

Top module: `seqctl_dispatch`

## Requirements
- R1: After reset the block requests address 0, and eng_valid, msg_ready and err are all low.
- R2: The opcode is instruction bits 63-60. Every instruction that does not take a jump moves the instruction pointer on by one. PREFETCH (0xC), MODULATOR (0xA) and the unassigned codes 0xD-0xF have no other effect. The memory is read exactly once per instruction.
- R3: WAVEFORM (0x0), MARKER (0x1), WAIT (0x2) and SYNC (0x9) are presented on eng_instr as the whole word, with eng_sel equal to bits 59-58. The word stays stable while eng_ready is low, and nothing further is fetched until it is accepted.
- R4: LOAD_REPEAT (0x3) loads bits 15-0 into the repeat counter. REPEAT (0x4) lowers a non-zero counter by one and jumps to its target when the new value is non-zero. A zero counter stays zero and does not jump.
- R5: CMP (0x5) compares the condition register (zero after reset) with mask bits 7-0, using operator bits 9-8: 0 equal, 1 not equal, 2 greater than, 3 less than.
- R6: GOTO (0x6), CALL (0x7) and RETURN (0x8) are skipped if the latest CMP that has not yet been consumed was false. Each of them consumes the result. Any other instruction leaves the result pending. With no pending result they always execute.
- R7: A taken CALL saves the address after the CALL together with the repeat counter, then jumps. A taken RETURN restores both.
- R8: The stack holds 8 entries. A taken CALL on a full stack, or a taken RETURN on an empty one, sets err. err stays set, and no further fetch or emission happens until reset.
- R9: LOAD_CMP (0xB) raises msg_ready only while it waits. It holds dispatch until msg_valid and loads msg_data into the condition register.
- R10: After a SYNC word is accepted, no fetch happens until engines_idle is high.
- R11: Jump targets are bits 25-0 of the instruction, truncated to the AW address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_addr | output | AW | Instruction memory read address |
| imem_rdata | input | 64 | Read data, valid one cycle after imem_rd |
| eng_valid | output | 1 | Engine-bound instruction available |
| eng_ready | input | 1 | Engines accept the instruction |
| eng_sel | output | 2 | Engine-select field of the presented word |
| eng_instr | output | 64 | Full engine-bound instruction word |
| msg_valid | input | 1 | Message available |
| msg_ready | output | 1 | Message taken when msg_valid is high |
| msg_data | input | 8 | Message value for the condition register |
| engines_idle | input | 1 | Engines have drained all queued work |
| err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Directed programs each isolate one mechanism. They cover straight-line no-ops and emissions, loop counts including a zero count, every compare operator with pending results crossing non-branch instructions, nested calls that must restore the loop counter, stack overflow and underflow, stalls on a missing message or busy engines, and targets carrying bits above the address width. Random programs of all opcodes run from random messages with random engine back-pressure. They show whether these mechanisms still agree when mixed. The fetch address trace separates wrong jump decisions from wrong stack contents. The emitted words separate skipped or duplicated engine traffic.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

  localparam int INSTR_W = 64;
  localparam int RPT_W   = 16;
  localparam int CMP_W   = 8;

  localparam logic [3:0] OP_WAVE  = 4'h0;
  localparam logic [3:0] OP_MARK  = 4'h1;
  localparam logic [3:0] OP_WAIT  = 4'h2;
  localparam logic [3:0] OP_LDRPT = 4'h3;
  localparam logic [3:0] OP_RPT   = 4'h4;
  localparam logic [3:0] OP_CMP   = 4'h5;
  localparam logic [3:0] OP_GOTO  = 4'h6;
  localparam logic [3:0] OP_CALL  = 4'h7;
  localparam logic [3:0] OP_RET   = 4'h8;
  localparam logic [3:0] OP_SYNC  = 4'h9;
  localparam logic [3:0] OP_LDCMP = 4'hB;

  typedef enum logic [2:0] {
    S_FETCH, S_LATCH, S_EXEC, S_EMIT, S_MSG, S_SYNC, S_HALT
  } disp_state_e;

  // Compare the condition register against a mask with a 2-bit operator.
  function automatic logic cmp_eval(input logic [1:0] code,
                                    input logic [CMP_W-1:0] val,
                                    input logic [CMP_W-1:0] mask);
    case (code)
      2'd0:    return val == mask;
      2'd1:    return val != mask;
      2'd2:    return val > mask;
      default: return val < mask;
    endcase
  endfunction

  // Loop counter step: zero saturates, anything else counts down.
  function automatic logic [RPT_W-1:0] rpt_dec(input logic [RPT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  function automatic logic is_engine_op(input logic [3:0] op);
    return (op == OP_WAVE) || (op == OP_MARK) || (op == OP_WAIT) || (op == OP_SYNC);
  endfunction

endpackage

// File: rtl/seqctl_stack.sv
module seqctl_stack #(
  parameter int W     = 22,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [IW-1:0] wr_idx, rd_idx;

  assign wr_idx = IW'(cnt);
  assign rd_idx = IW'(cnt - 1'b1);
  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign dout   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (push && !full)     cnt <= cnt + 1'b1;
    else if (pop && !empty)     cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= din;
  end
endmodule

// File: rtl/seqctl_cond.sv
module seqctl_cond
  import seqctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_load,
  input  logic [CMP_W-1:0] msg_val,
  input  logic             cmp_en,
  input  logic [1:0]       cmp_code,
  input  logic [CMP_W-1:0] cmp_mask,
  input  logic             consume,
  output logic             take_ok
);
  logic [CMP_W-1:0] creg;
  logic             flag, armed;

  assign take_ok = !armed || flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      creg  <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (msg_load) creg <= msg_val;
      if (cmp_en) begin
        flag  <= cmp_eval(cmp_code, creg, cmp_mask);
        armed <= 1'b1;
      end else if (consume) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seqctl_dispatch.sv
module seqctl_dispatch
  import seqctl_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               imem_rd,
  output logic [AW-1:0]      imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic               eng_valid,
  input  logic               eng_ready,
  output logic [1:0]         eng_sel,
  output logic [INSTR_W-1:0] eng_instr,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [CMP_W-1:0]   msg_data,
  input  logic               engines_idle,
  output logic               err
);
  localparam int FW = AW + RPT_W;

  disp_state_e        state;
  logic [INSTR_W-1:0] ir;
  logic [AW-1:0]      ip, ip_inc, tgt;
  logic [RPT_W-1:0]   rpt, rpt_nx;
  logic [3:0]         op;
  logic [FW-1:0]      stk_dout;
  logic               stk_full, stk_empty, take_ok;

  // named internal events, used by the bound checker
  logic in_exec, is_branch, ev_consume, ev_cmp, ev_push, ev_pop, ev_fault;
  logic ev_msg, sync_wait;

  assign op     = ir[63:60];
  assign tgt    = ir[AW-1:0];
  assign ip_inc = ip + 1'b1;
  assign rpt_nx = rpt_dec(rpt);

  assign in_exec    = (state == S_EXEC);
  assign is_branch  = (op == OP_GOTO) || (op == OP_CALL) || (op == OP_RET);
  assign ev_consume = in_exec && is_branch;
  assign ev_cmp     = in_exec && (op == OP_CMP);
  assign ev_push    = in_exec && (op == OP_CALL) && take_ok && !stk_full;
  assign ev_pop     = in_exec && (op == OP_RET) && take_ok && !stk_empty;
  assign ev_fault   = in_exec && take_ok &&
                      (((op == OP_CALL) && stk_full) || ((op == OP_RET) && stk_empty));
  assign ev_msg     = (state == S_MSG) && msg_valid;
  assign sync_wait  = (state == S_SYNC);

  seqctl_cond cond_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_load (ev_msg),
    .msg_val  (msg_data),
    .cmp_en   (ev_cmp),
    .cmp_code (ir[9:8]),
    .cmp_mask (ir[7:0]),
    .consume  (ev_consume),
    .take_ok  (take_ok)
  );

  seqctl_stack #(.W(FW), .DEPTH(DEPTH)) stack_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_push),
    .pop   (ev_pop),
    .din   ({ip_inc, rpt}),
    .dout  (stk_dout),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      ip    <= '0;
      rpt   <= '0;
      ir    <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        S_FETCH: state <= S_LATCH;
        S_LATCH: begin
          ir    <= imem_rdata;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          ip    <= ip_inc;
          if (is_engine_op(op)) begin
            state <= S_EMIT;
            ip    <= ip;
          end else if (ev_fault) begin
            err   <= 1'b1;
            state <= S_HALT;
            ip    <= ip;
          end else begin
            case (op)
              OP_LDRPT: rpt <= ir[RPT_W-1:0];
              OP_RPT: begin
                rpt <= rpt_nx;
                if (rpt_nx != '0) ip <= tgt;
              end
              OP_GOTO, OP_CALL: if (take_ok) ip <= tgt;
              OP_RET: if (ev_pop) {ip, rpt} <= stk_dout;
              OP_LDCMP: begin
                state <= S_MSG;
                ip    <= ip;
              end
              default: ;
            endcase
          end
        end
        S_EMIT: begin
          if (eng_ready) begin
            if (op == OP_SYNC) begin
              state <= S_SYNC;
            end else begin
              ip    <= ip_inc;
              state <= S_FETCH;
            end
          end
        end
        S_SYNC: begin
          if (engines_idle) begin
            ip    <= ip_inc;
            state <= S_FETCH;
          end
        end
        S_MSG: begin
          if (msg_valid) begin
            ip    <= ip_inc;
            state <= S_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  assign imem_rd   = (state == S_FETCH);
  assign imem_addr = ip;
  assign eng_valid = (state == S_EMIT);
  assign eng_instr = ir;
  assign eng_sel   = ir[59:58];
  assign msg_ready = (state == S_MSG);

endmodule

// File: rtl/seqctl_dispatch_chk.sv
module seqctl_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        imem_rd,
  input logic        eng_valid,
  input logic        eng_ready,
  input logic [63:0] eng_instr,
  input logic        msg_ready,
  input logic        err,
  input logic        ev_push,
  input logic        stk_empty,
  input logic        sync_wait,
  input logic        engines_idle
);
  // R2: one read per instruction, never back to back
  a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> !imem_rd);

  // R3: offered word held until taken
  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_instr));

  // R7: a push always leaves something to return to
  a_r7_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> !stk_empty);

  // R8: error is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8: halted block stays quiet
  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !imem_rd && !eng_valid);

  // R9: message wait excludes other activity
  a_r9_msg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> !imem_rd && !eng_valid);

  // R10: no fetch while engines are busy after a sync
  a_r10_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sync_wait && !engines_idle |=> !imem_rd);
endmodule

bind seqctl_dispatch seqctl_dispatch_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .imem_rd      (imem_rd),
  .eng_valid    (eng_valid),
  .eng_ready    (eng_ready),
  .eng_instr    (eng_instr),
  .msg_ready    (msg_ready),
  .err          (err),
  .ev_push      (ev_push),
  .stk_empty    (stk_empty),
  .sync_wait    (sync_wait),
  .engines_idle (engines_idle)
);

// File: tb/seqctl_dispatch_tb.sv
`timescale 1ns/1ps
module seqctl_dispatch_tb_top;
  localparam int AWT = 6;
  localparam int MSZ = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_rd;
  logic [AWT-1:0] imem_addr;
  logic [63:0] imem_rdata = '0;
  logic        eng_valid;
  logic        eng_ready = 1'b0;
  logic [1:0]  eng_sel;
  logic [63:0] eng_instr;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [7:0]  msg_data = '0;
  logic        engines_idle = 1'b0;
  logic        err;

  logic [63:0] mem [MSZ];
  logic [7:0]  msgs [256];
  int          nmsg = 0;
  int          mi = 0;
  bit          msg_block = 0, idle_block = 0;
  int          maxf_cur = 0;
  logic [AWT-1:0] dut_fetch[$], exp_fetch[$];
  logic [65:0]    dut_emit[$],  exp_emit[$];
  bit          exp_err;
  int          nchk = 0, nfail = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  seqctl_dispatch #(.AW(AWT), .DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .imem_rd(imem_rd), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_sel(eng_sel), .eng_instr(eng_instr), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_data(msg_data), .engines_idle(engines_idle),
    .err(err)
  );

  always @(posedge clk) if (imem_rd) imem_rdata <= mem[imem_addr];

  // drive random handshake inputs, then sample what the next edge will do
  always @(negedge clk) begin
    eng_ready    = ($urandom % 4) != 0;
    engines_idle = idle_block ? 1'b0 : (($urandom % 3) != 0);
    if (!msg_block && mi < nmsg) begin
      msg_valid = ($urandom % 2) != 0;
      msg_data  = msgs[mi];
    end else begin
      msg_valid = 1'b0;
    end
    #1;
    if (rst_n) begin
      if (imem_rd && dut_fetch.size() < maxf_cur) dut_fetch.push_back(imem_addr);
      if (eng_valid && eng_ready) dut_emit.push_back({eng_sel, eng_instr});
      if (msg_valid && msg_ready) mi++;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [65:0] act, logic [65:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [63:0] ins(logic [3:0] op, logic [1:0] sel, bit wr, logic [55:0] pl);
    return {op, sel, 1'b0, wr, pl};
  endfunction

  function automatic bit ref_cmp(logic [1:0] code, logic [7:0] v, logic [7:0] m);
    if (code == 2'd0) return v == m;
    if (code == 2'd1) return v != m;
    if (code == 2'd2) return v > m;
    return v < m;
  endfunction

  // Instruction-level reference built from the requirements
  task automatic model_run(int maxf);
    logic [AWT-1:0] ip = '0, nip, tgt;
    logic [15:0] rpt = '0;
    logic [7:0]  creg = '0;
    bit flag = 0, armed = 0, take;
    logic [AWT+15:0] stk [8];
    int sp = 0, m2 = 0;
    logic [63:0] w;
    logic [3:0] op;
    exp_fetch.delete(); exp_emit.delete(); exp_err = 0;
    while (exp_fetch.size() < maxf) begin
      w = mem[ip]; op = w[63:60]; tgt = w[AWT-1:0]; nip = ip + 1'b1;
      exp_fetch.push_back(ip);
      if (op == 4'h0 || op == 4'h1 || op == 4'h2 || op == 4'h9) exp_emit.push_back({w[59:58], w});
      else if (op == 4'h3) rpt = w[15:0];
      else if (op == 4'h4) begin
        if (rpt != 0) rpt = rpt - 1'b1;
        if (rpt != 0) nip = tgt;
      end
      else if (op == 4'h5) begin flag = ref_cmp(w[9:8], creg, w[7:0]); armed = 1; end
      else if (op == 4'h6 || op == 4'h7 || op == 4'h8) begin
        take = !armed || flag; armed = 0;
        if (take && op == 4'h6) nip = tgt;
        if (take && op == 4'h7) begin
          if (sp == 8) begin exp_err = 1; break; end
          stk[sp] = {ip + 1'b1, rpt}; sp++; nip = tgt;
        end
        if (take && op == 4'h8) begin
          if (sp == 0) begin exp_err = 1; break; end
          sp--; {nip, rpt} = stk[sp];
        end
      end
      else if (op == 4'hB) begin
        if (m2 >= nmsg) break;
        creg = msgs[m2]; m2++;
      end
      ip = nip;
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MSZ; i++) mem[i] = ins(4'h6, 2'd0, 0, 56'd0);
  endtask

  // mode 0: free run; 1: messages withheld at first; 2: engines busy at first
  task automatic run_prog(string tag, int maxf, int mode, int stall_fetch);
    int n;
    rst_n = 0; maxf_cur = maxf;
    msg_block = (mode == 1); idle_block = (mode == 2);
    repeat (3) @(negedge clk);
    dut_fetch.delete(); dut_emit.delete(); mi = 0;
    model_run(maxf);
    @(negedge clk); rst_n = 1;
    if (mode != 0) begin
      repeat (40) @(negedge clk);
      #2;
      chk(dut_fetch.size() == stall_fetch, tag, "fetches while stalled", dut_fetch.size(), stall_fetch);
      if (mode == 1) chk(msg_ready == 1'b1, tag, "msg_ready while waiting", msg_ready, 1);
      if (mode == 2) chk(dut_emit.size() == 1, tag, "sync word emitted once", dut_emit.size(), 1);
      msg_block = 0; idle_block = 0;
    end
    n = 0;
    while ((dut_fetch.size() < exp_fetch.size() || dut_emit.size() < exp_emit.size()) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (20) @(negedge clk);
    #2;
    chk(dut_fetch.size() >= exp_fetch.size(), tag, "fetch count", dut_fetch.size(), exp_fetch.size());
    for (int i = 0; i < exp_fetch.size(); i++)
      if (i < dut_fetch.size())
        chk(dut_fetch[i] == exp_fetch[i], tag, $sformatf("fetch[%0d]", i), dut_fetch[i], exp_fetch[i]);
    chk(dut_emit.size() >= exp_emit.size(), tag, "emit count", dut_emit.size(), exp_emit.size());
    for (int i = 0; i < exp_emit.size(); i++)
      if (i < dut_emit.size())
        chk(dut_emit[i] == exp_emit[i], tag, $sformatf("emit[%0d]", i), dut_emit[i], exp_emit[i]);
    if (exp_err) begin
      chk(err == 1'b1, tag, "err flag", err, 1);
      chk(dut_fetch.size() == exp_fetch.size(), tag, "no fetch after error", dut_fetch.size(), exp_fetch.size());
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_mem();
    repeat (4) @(negedge clk);
    rst_n = 1;
    #2;
    // R1 reset state
    chk(imem_rd == 1'b1, "R1", "imem_rd", imem_rd, 1);
    chk(imem_addr == '0, "R1", "imem_addr", imem_addr, 0);
    chk(eng_valid == 1'b0, "R1", "eng_valid", eng_valid, 0);
    chk(msg_ready == 1'b0, "R1", "msg_ready", msg_ready, 0);
    chk(err == 1'b0, "R1", "err", err, 0);

    // R2 and R3: no-ops and engine words
    clear_mem();
    mem[0] = ins(4'h0, 2'd2, 1, 56'h123456789ABCDE);
    mem[1] = ins(4'h1, 2'd1, 0, 56'h00001E00000040);
    mem[2] = ins(4'hC, 2'd0, 0, 56'd3);
    mem[3] = ins(4'hA, 2'd0, 0, 56'd9);
    mem[4] = ins(4'hE, 2'd0, 0, 56'd1);
    mem[5] = ins(4'h2, 2'd3, 1, 56'h400000000000);
    mem[6] = ins(4'hD, 2'd0, 0, 56'd2);
    mem[7] = ins(4'h6, 2'd0, 0, 56'd0);
    nmsg = 0;
    run_prog("R2_R3", 16, 0, 0);

    // R4: loop counts, zero counter
    clear_mem();
    mem[0] = ins(4'h3, 2'd0, 0, 56'd2);
    mem[1] = ins(4'h0, 2'd0, 1, 56'd77);
    mem[2] = ins(4'h4, 2'd0, 0, 56'd1);
    mem[3] = ins(4'h3, 2'd0, 0, 56'd0);
    mem[4] = ins(4'h4, 2'd0, 0, 56'd6);
    mem[5] = ins(4'h1, 2'd0, 1, 56'd5);
    mem[6] = ins(4'h4, 2'd0, 0, 56'd0);
    mem[7] = ins(4'h6, 2'd0, 0, 56'd0);
    run_prog("R4", 20, 0, 0);

    // R5 and R6: operators and pending results
    clear_mem();
    msgs[0] = 8'h80; msgs[1] = 8'h30; msgs[2] = 8'h40; nmsg = 3;
    mem[0]  = ins(4'hB, 2'd0, 0, 56'd0);
    mem[1]  = ins(4'h5, 2'd0, 0, {46'd0, 2'd2, 8'h40});
    mem[2]  = ins(4'h6, 2'd0, 0, 56'd4);
    mem[3]  = ins(4'h0, 2'd0, 1, 56'd1);
    mem[4]  = ins(4'h5, 2'd0, 0, {46'd0, 2'd3, 8'h40});
    mem[5]  = ins(4'h6, 2'd0, 0, 56'd20);
    mem[6]  = ins(4'h5, 2'd0, 0, {46'd0, 2'd1, 8'h80});
    mem[7]  = ins(4'h0, 2'd0, 1, 56'd2);
    mem[8]  = ins(4'h6, 2'd0, 0, 56'd12);
    mem[9]  = ins(4'h5, 2'd0, 0, {46'd0, 2'd0, 8'h80});
    mem[10] = ins(4'h6, 2'd0, 0, 56'd12);
    mem[12] = ins(4'h1, 2'd0, 1, 56'd3);
    mem[13] = ins(4'h6, 2'd0, 0, 56'd0);
    run_prog("R5_R6", 40, 0, 0);

    // R7: nested call restores the loop counter
    clear_mem();
    mem[0]  = ins(4'h3, 2'd0, 0, 56'd1);
    mem[1]  = ins(4'h7, 2'd0, 0, 56'd10);
    mem[2]  = ins(4'h4, 2'd0, 0, 56'd1);
    mem[3]  = ins(4'h1, 2'd0, 1, 56'd8);
    mem[4]  = ins(4'h6, 2'd0, 0, 56'd0);
    mem[10] = ins(4'h3, 2'd0, 0, 56'd5);
    mem[11] = ins(4'h7, 2'd0, 0, 56'd20);
    mem[12] = ins(4'h8, 2'd0, 0, 56'd0);
    mem[20] = ins(4'h0, 2'd1, 1, 56'd4);
    mem[21] = ins(4'h8, 2'd0, 0, 56'd0);
    run_prog("R7", 30, 0, 0);

    // R8: overflow, then underflow
    clear_mem();
    mem[0] = ins(4'h7, 2'd0, 0, 56'd0);
    run_prog("R8_overflow", 30, 0, 0);
    clear_mem();
    mem[0] = ins(4'h0, 2'd0, 1, 56'd1);
    mem[1] = ins(4'h8, 2'd0, 0, 56'd0);
    run_prog("R8_underflow", 30, 0, 0);

    // R9: stall for a message
    clear_mem();
    msgs[0] = 8'h5A; msgs[1] = 8'h11; nmsg = 2;
    mem[0] = ins(4'hB, 2'd0, 0, 56'hFFFF);
    mem[1] = ins(4'h5, 2'd0, 0, {46'd0, 2'd0, 8'h5A});
    mem[2] = ins(4'h6, 2'd0, 0, 56'd5);
    mem[3] = ins(4'h0, 2'd0, 1, 56'd1);
    mem[4] = ins(4'h6, 2'd0, 0, 56'd0);
    mem[5] = ins(4'h0, 2'd0, 1, 56'd2);
    mem[6] = ins(4'h6, 2'd0, 0, 56'd0);
    run_prog("R9", 8, 1, 1);

    // R10: sync waits for idle engines
    clear_mem();
    nmsg = 0;
    mem[0] = ins(4'h9, 2'd0, 1, 56'h800000000000);
    mem[1] = ins(4'h0, 2'd0, 1, 56'd6);
    mem[2] = ins(4'h6, 2'd0, 0, 56'd0);
    run_prog("R10", 9, 2, 1);

    // R11: upper target bits dropped
    clear_mem();
    mem[0] = ins(4'h6, 2'd0, 0, 56'h3FFFFC5);
    mem[5] = ins(4'h0, 2'd0, 1, 56'd9);
    mem[6] = ins(4'h6, 2'd0, 0, 56'h3000000);
    run_prog("R11", 10, 0, 0);

    // random programs mixing all opcodes (R6 and neighbours)
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < MSZ; i++)
        mem[i] = {$urandom, $urandom};
      for (int i = 0; i < 256; i++) msgs[i] = 8'($urandom);
      nmsg = 256;
      run_prog("R6_random", 60, 0, 0);
    end

    summary();
    $finish;
  end
endmodule